// File: doc/BRIEF.md
# Flash Array Controller

This block models an on-chip non-volatile memory controller together with the small flash array it manages. It has two 32-bit bus ports. A register port holds the operating mode, a ready indication and the erase commands. A memory port performs word reads and word writes to a main region and to a separate user-settings region. Programming follows flash rules. A word write can only clear bits, because the stored word becomes the old word ANDed with the new value. Erasing is the only way to return words to all ones.

The operating mode gates everything that changes the array. In mode 1, word writes program the array. In mode 2, erase commands are accepted. Any other mode leaves the array read-only. An accepted erase runs one word per clock. While it runs, the memory port drops `memReady` and ignores accesses, but the ready register still reads 1. The main region sits at byte address 0. The user region sits at `USER_BASE`. Reads return their data one cycle after the request.

Top module: `nvm_flash_ctrl`

## Requirements
- R1: After reset the mode reads 0 and every word of both regions reads 0xFFFFFFFF.
- R2: The mode register at register offset 0x00 stores bits [1:0] of a write and reads them back exactly, including the value 3, with the upper bits reading 0.
- R3: The ready register at offset 0x04 always reads 0x00000001, even while an erase is in progress.
- R4: In mode 1, a word write to a mapped array address stores the old word ANDed with the written value, so a word that was erased reads back exactly the value written.
- R5: In mode 0, mode 2 or mode 3, array word writes leave the stored contents unchanged.
- R6: In mode 2, writing a byte address inside the main region to offset 0x08 or to offset 0x0C sets every word of page (address / (4*PAGE_WORDS)) to ones and leaves all other words unchanged.
- R7: A page-erase write whose address is at or beyond the end of the main region does nothing and does not stall the memory port.
- R8: In mode 2, writing a value with bit 0 set to offset 0x10 sets every main-region word to ones and leaves the user region unchanged.
- R9: In mode 2, writing a value with bit 0 set to offset 0x14 sets every user-region word to ones and leaves the main region unchanged.
- R10: Erase command writes made in any mode other than 2 are ignored.
- R11: An accepted erase holds `memReady` low for exactly as many cycles as the words it erases, and memory reads and writes presented while `memReady` is low are ignored.
- R12: A memory read loads `memRdata` on the next clock edge. A read at an address in neither region returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| regWrEn | input | 1 | Register port write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memWrEn | input | 1 | Array word write strobe |
| memRdEn | input | 1 | Array word read strobe |
| memAddr | input | 32 | Array byte address (word aligned) |
| memWdata | input | 32 | Array write data |
| memRdata | output | 32 | Array read data, registered |
| memReady | output | 1 | Low while an erase sweep is running |

## Verification
The assertions assume word-aligned memory addresses and a user region placed above the end of the main region. They also assume the bench presents array accesses only while `memReady` is high, except for one deliberate write during an erase. The stimulus follows these assumptions. It derives every address from a word index. It waits for `memReady` after each erase command before the next access. It places the single stalled write inside a page-erase window whose length it has computed. Out-of-range and unmapped addresses are chosen just past each region boundary, so that off-by-one decoding shows up.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [7:0] OFF_MODE   = 8'h00;
  localparam logic [7:0] OFF_READY  = 8'h04;
  localparam logic [7:0] OFF_PAGE_A = 8'h08;
  localparam logic [7:0] OFF_PAGE_B = 8'h0C;
  localparam logic [7:0] OFF_ALL    = 8'h10;
  localparam logic [7:0] OFF_USER   = 8'h14;

  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_PROG = 2'd1,
    MODE_WIPE = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic progWord;
    logic wipeWord;
    logic loadRead;
    logic loadZero;
  } dp_strobe_t;
endpackage

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int          NUM_PAGES  = 256,
  parameter int          PAGE_WORDS = 4,
  parameter int          USER_WORDS = 16,
  parameter logic [31:0] USER_BASE  = 32'h1000_0000,
  parameter int          IDX_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regWrEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             memWrEn,
  input  logic             memRdEn,
  input  logic [31:0]      memAddr,
  output logic             memReady,
  output dp_strobe_t       stb,
  output logic [IDX_W-1:0] accIdx,
  output logic [IDX_W-1:0] wipeIdx,
  output logic [1:0]       modeOut
);
  localparam int MAIN_WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int TOTAL      = MAIN_WORDS + USER_WORDS;
  localparam logic [31:0] PAGE_BYTES = 32'(PAGE_WORDS * 4);
  localparam logic [31:0] MAIN_BYTES = 32'(MAIN_WORDS * 4);
  localparam logic [31:0] USER_BYTES = 32'(USER_WORDS * 4);
  localparam logic [IDX_W-1:0] MAIN_END   = IDX_W'(MAIN_WORDS - 1);
  localparam logic [IDX_W-1:0] USER_FIRST = IDX_W'(MAIN_WORDS);
  localparam logic [IDX_W-1:0] USER_END   = IDX_W'(TOTAL - 1);

  mode_e            modeQ;
  logic             busyQ;
  logic [IDX_W-1:0] curQ, lastQ;

  // erase command decode
  logic             wipeOk, pageCmd, allCmd, userCmd, anyCmd;
  logic [31:0]      pageFirst;
  logic [IDX_W-1:0] startIdx, endIdx;

  always_comb begin
    wipeOk    = regWrEn && !busyQ && (modeQ == MODE_WIPE);
    pageCmd   = wipeOk && ((regAddr == OFF_PAGE_A) || (regAddr == OFF_PAGE_B))
                && (regWdata < MAIN_BYTES);
    allCmd    = wipeOk && (regAddr == OFF_ALL) && regWdata[0];
    userCmd   = wipeOk && (regAddr == OFF_USER) && regWdata[0];
    anyCmd    = pageCmd || allCmd || userCmd;
    pageFirst = (regWdata / PAGE_BYTES) * 32'(PAGE_WORDS);
    if (userCmd) begin
      startIdx = USER_FIRST;
      endIdx   = USER_END;
    end else if (allCmd) begin
      startIdx = '0;
      endIdx   = MAIN_END;
    end else begin
      startIdx = IDX_W'(pageFirst);
      endIdx   = IDX_W'(pageFirst + 32'(PAGE_WORDS - 1));
    end
  end

  // erase sweep: one word per clock
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busyQ <= 1'b0;
      curQ  <= '0;
      lastQ <= '0;
    end else if (busyQ) begin
      if (curQ == lastQ) busyQ <= 1'b0;
      else               curQ  <= curQ + 1'b1;
    end else if (anyCmd) begin
      busyQ <= 1'b1;
      curQ  <= startIdx;
      lastQ <= endIdx;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                                 modeQ <= MODE_READ;
    else if (regWrEn && regAddr == OFF_MODE) modeQ <= mode_e'(regWdata[1:0]);
  end

  always_comb begin
    case (regAddr)
      OFF_MODE:  regRdata = {30'd0, modeQ};
      OFF_READY: regRdata = 32'd1;
      default:   regRdata = 32'd0;
    endcase
  end

  // memory port decode
  logic [31:0] userOff;
  logic        mainHit, userHit, hit;

  always_comb begin
    userOff = memAddr - USER_BASE;
    mainHit = memAddr < MAIN_BYTES;
    userHit = (memAddr >= USER_BASE) && (userOff < USER_BYTES);
    hit     = mainHit || userHit;
    accIdx  = mainHit ? IDX_W'(memAddr >> 2)
                      : IDX_W'(32'(MAIN_WORDS) + (userOff >> 2));
  end

  assign memReady     = !busyQ;
  assign wipeIdx      = curQ;
  assign modeOut      = modeQ;
  assign stb.progWord = memWrEn && memReady && hit && (modeQ == MODE_PROG);
  assign stb.wipeWord = busyQ;
  assign stb.loadRead = memRdEn && memReady && hit;
  assign stb.loadZero = memRdEn && memReady && !hit;
endmodule

// File: rtl/nvm_datapath.sv
module nvm_datapath
  import nvm_pkg::*;
#(
  parameter int TOTAL = 1040,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  dp_strobe_t       stb,
  input  logic [IDX_W-1:0] accIdx,
  input  logic [IDX_W-1:0] wipeIdx,
  input  logic [31:0]      memWdata,
  output logic [31:0]      memRdata
);
  logic [31:0] cells [TOTAL];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < TOTAL; i++) cells[i] <= '1;
      memRdata <= '0;
    end else begin
      if (stb.wipeWord) cells[wipeIdx] <= '1;
      if (stb.progWord) cells[accIdx] <= cells[accIdx] & memWdata;
      if (stb.loadRead)      memRdata <= cells[accIdx];
      else if (stb.loadZero) memRdata <= '0;
    end
  end
endmodule

// File: rtl/nvm_flash_ctrl.sv
module nvm_flash_ctrl
  import nvm_pkg::*;
#(
  parameter int          NUM_PAGES  = 256,
  parameter int          PAGE_WORDS = 4,
  parameter int          USER_WORDS = 16,
  parameter logic [31:0] USER_BASE  = 32'h1000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        memWrEn,
  input  logic        memRdEn,
  input  logic [31:0] memAddr,
  input  logic [31:0] memWdata,
  output logic [31:0] memRdata,
  output logic        memReady
);
  localparam int TOTAL = NUM_PAGES * PAGE_WORDS + USER_WORDS;
  localparam int IDX_W = $clog2(TOTAL);

  dp_strobe_t       stb;
  logic [IDX_W-1:0] accIdx, wipeIdx;
  logic [1:0]       modeQ;

  nvm_ctrl #(
    .NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS), .USER_WORDS(USER_WORDS),
    .USER_BASE(USER_BASE), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memReady(memReady), .stb(stb),
    .accIdx(accIdx), .wipeIdx(wipeIdx), .modeOut(modeQ)
  );

  nvm_datapath #(.TOTAL(TOTAL), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .accIdx(accIdx), .wipeIdx(wipeIdx),
    .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: rtl/nvm_flash_ctrl_chk.sv
module nvm_flash_ctrl_chk
  import nvm_pkg::*;
#(
  parameter logic [31:0] MAIN_BYTES = 32'h1000,
  parameter logic [31:0] USER_BASE  = 32'h1000_0000,
  parameter logic [31:0] USER_BYTES = 32'h40
) (
  input logic        clk,
  input logic        rst,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic [1:0]  regWdataLo,
  input logic [31:0] regRdata,
  input logic        memRdEn,
  input logic [31:0] memAddr,
  input logic        memReady,
  input logic [31:0] memRdata,
  input logic [1:0]  mode
);
  logic unmapped;
  assign unmapped = (memAddr >= MAIN_BYTES) &&
                    !((memAddr >= USER_BASE) && (memAddr - USER_BASE < USER_BYTES));

  AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
    (regAddr == OFF_READY) |-> (regRdata == 32'd1)); // R3

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == OFF_MODE) |=> (mode == $past(regWdataLo))); // R2

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && regAddr == OFF_MODE) |=> $stable(mode)); // R2

  AST_ERASE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    $fell(memReady) |-> ($past(mode) == 2'd2)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (memRdEn && memReady && unmapped) |=> (memRdata == 32'd0)); // R12
endmodule

bind nvm_flash_ctrl nvm_flash_ctrl_chk #(
  .MAIN_BYTES(32'(NUM_PAGES * PAGE_WORDS * 4)),
  .USER_BASE(USER_BASE),
  .USER_BYTES(32'(USER_WORDS * 4))
) u_chk (
  .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWdataLo(regWdata[1:0]), .regRdata(regRdata), .memRdEn(memRdEn),
  .memAddr(memAddr), .memReady(memReady), .memRdata(memRdata), .mode(modeQ)
);

// File: tb/nvm_flash_ctrl_bench.sv
module nvm_flash_ctrl_bench;
  localparam int          NUM_PAGES  = 256;
  localparam int          PAGE_WORDS = 4;
  localparam int          USER_WORDS = 16;
  localparam logic [31:0] USER_BASE  = 32'h1000_0000;
  localparam int          MAIN_WORDS = NUM_PAGES * PAGE_WORDS;
  localparam int          TOTAL      = MAIN_WORDS + USER_WORDS;
  localparam logic [31:0] PAGE_BYTES = 32'(PAGE_WORDS * 4);
  localparam logic [31:0] MAIN_BYTES = 32'(MAIN_WORDS * 4);
  localparam logic [31:0] USER_BYTES = 32'(USER_WORDS * 4);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0, memWrEn = 1'b0, memRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0, memAddr = '0, memWdata = '0;
  logic [31:0] regRdata, memRdata;
  logic        memReady;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [TOTAL];

  always #2 clk = ~clk;

  nvm_flash_ctrl #(
    .NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS),
    .USER_WORDS(USER_WORDS), .USER_BASE(USER_BASE)
  ) u_nvm_flash_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memWrEn(memWrEn),
    .memRdEn(memRdEn), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  function automatic logic [31:0] addrOf(int i);
    if (i < MAIN_WORDS) return 32'(i * 4);
    return USER_BASE + 32'((i - MAIN_WORDS) * 4);
  endfunction

  function automatic logic [31:0] pat(int i, logic [31:0] salt);
    return (32'(i) * 32'h9E37_79B1) ^ salt;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic memWr(input logic [31:0] a, input logic [31:0] d);
    memWrEn = 1'b1; memAddr = a; memWdata = d;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  task automatic memRd(input logic [31:0] a, output logic [31:0] d);
    memRdEn = 1'b1; memAddr = a;
    @(negedge clk);
    memRdEn = 1'b0;
    d = memRdata;
  endtask

  task automatic waitIdle(output int cnt);
    cnt = 0;
    while (!memReady) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic sweep(input string tag);
    logic [31:0] v;
    for (int i = 0; i < TOTAL; i++) begin
      memRd(addrOf(i), v);
      check(v == model[i], tag, v, model[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    for (int i = 0; i < TOTAL; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    regRd(8'h00, v); check(v == 0, "R1 mode after reset", v, 0);
    regRd(8'h04, v); check(v == 1, "R3 ready after reset", v, 1);
    sweep("R1 array all ones after reset");

    // R2 mode readback
    for (int m = 0; m < 4; m++) begin
      regWr(8'h00, 32'hFFFF_FFF0 | 32'(m));
      regRd(8'h00, v);
      check(v == 32'(m), "R2 mode readback", v, 32'(m));
    end

    // R5 writes ignored outside mode 1
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      regWr(8'h00, 32'(m));
      memWr(addrOf(5), 32'h0);
      memWr(addrOf(MAIN_WORDS + 2), 32'h0);
      memRd(addrOf(5), v); check(v == '1, "R5 main write ignored", v, '1);
      memRd(addrOf(MAIN_WORDS + 2), v); check(v == '1, "R5 user write ignored", v, '1);
    end

    // R4 fill both regions, then AND over part of them
    regWr(8'h00, 32'd1);
    for (int i = 0; i < TOTAL; i++) begin
      memWr(addrOf(i), pat(i, 32'h0F0F_5A5A));
      model[i] = pat(i, 32'h0F0F_5A5A);
    end
    sweep("R4 erased word reads back written value");
    for (int i = 0; i < 64; i++) begin
      memWr(addrOf(i), pat(i, 32'hC3C3_0000));
      model[i] = model[i] & pat(i, 32'hC3C3_0000);
      memWr(addrOf(MAIN_WORDS + (i % USER_WORDS)), 32'hFFFF_00FF);
      model[MAIN_WORDS + (i % USER_WORDS)] = model[MAIN_WORDS + (i % USER_WORDS)] & 32'hFFFF_00FF;
    end
    sweep("R4 program ANDs with stored word");

    // R10 erase commands ignored outside mode 2
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      regWr(8'h00, 32'(m));
      regWr(8'h10, 32'd1);
      check(memReady == 1'b1, "R10 erase-all ignored", 32'(memReady), 1);
      regWr(8'h14, 32'd1);
      regWr(8'h08, 32'd0);
      regWr(8'h0C, PAGE_BYTES);
      check(memReady == 1'b1, "R10 erase cmds ignored", 32'(memReady), 1);
    end
    sweep("R10 contents intact after ignored erases");

    // R6 page erase through both registers, R11 stall length, R3 ready while busy
    regWr(8'h00, 32'd2);
    regWr(8'h08, 3 * PAGE_BYTES + 32'd4);
    regRd(8'h04, v); check(v == 1, "R3 ready reads 1 during erase", v, 1);
    check(memReady == 1'b0, "R11 stall begins", 32'(memReady), 0);
    waitIdle(cnt);
    check(cnt == PAGE_WORDS, "R11 page stall length", 32'(cnt), 32'(PAGE_WORDS));
    for (int i = 3 * PAGE_WORDS; i < 4 * PAGE_WORDS; i++) model[i] = '1;
    regWr(8'h0C, MAIN_BYTES - PAGE_BYTES);
    waitIdle(cnt);
    check(cnt == PAGE_WORDS, "R11 page stall length B", 32'(cnt), 32'(PAGE_WORDS));
    for (int i = MAIN_WORDS - PAGE_WORDS; i < MAIN_WORDS; i++) model[i] = '1;
    sweep("R6 only addressed pages erased");

    // R7 out-of-range page address
    regWr(8'h08, MAIN_BYTES);
    check(memReady == 1'b1, "R7 no stall for out-of-range page", 32'(memReady), 1);
    regWr(8'h0C, 32'hFFFF_FFFC);
    check(memReady == 1'b1, "R7 no stall for far page", 32'(memReady), 1);
    sweep("R7 contents intact");

    // R11 write presented during an erase is ignored
    regWr(8'h08, 32'd0);
    regWr(8'h00, 32'd1);
    check(memReady == 1'b0, "R11 still busy", 32'(memReady), 0);
    memWr(addrOf(7 * PAGE_WORDS), 32'h0);
    waitIdle(cnt);
    for (int i = 0; i < PAGE_WORDS; i++) model[i] = '1;
    memRd(addrOf(7 * PAGE_WORDS), v);
    check(v == model[7 * PAGE_WORDS], "R11 stalled write ignored", v, model[7 * PAGE_WORDS]);

    // R9 user region erase
    regWr(8'h00, 32'd2);
    regWr(8'h14, 32'd1);
    waitIdle(cnt);
    check(cnt == USER_WORDS, "R11 user stall length", 32'(cnt), 32'(USER_WORDS));
    for (int i = MAIN_WORDS; i < TOTAL; i++) model[i] = '1;
    sweep("R9 user erased, main intact");

    // R8 erase all, with user region refilled first
    regWr(8'h00, 32'd1);
    for (int i = MAIN_WORDS; i < TOTAL; i++) begin
      memWr(addrOf(i), pat(i, 32'h1234_8765));
      model[i] = pat(i, 32'h1234_8765);
    end
    regWr(8'h00, 32'd2);
    regWr(8'h10, 32'd1);
    waitIdle(cnt);
    check(cnt == MAIN_WORDS, "R11 erase-all stall length", 32'(cnt), 32'(MAIN_WORDS));
    for (int i = 0; i < MAIN_WORDS; i++) model[i] = '1;
    sweep("R8 main erased, user intact");

    // R12 unmapped reads
    memRd(addrOf(MAIN_WORDS + 1), v);
    memRd(MAIN_BYTES, v); check(v == 0, "R12 read past main", v, 0);
    memRd(addrOf(MAIN_WORDS + 1), v);
    memRd(USER_BASE + USER_BYTES, v); check(v == 0, "R12 read past user", v, 0);
    memRd(USER_BASE - 32'd4, v); check(v == 0, "R12 read below user", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule